// File: doc/BRIEF.md
# Break idle-state output controller

This block sits at the pin end of a timer channel that drives a complementary output pair (a main output and its inverted partner) and one single-ended output. While the main output enable is high, the three pins pass the normal PWM levels through in the same cycle. When the main output enable goes low, each pin moves to a programmed idle level. The complementary pair first spends a programmable dead-time with both pins low, so the two switches never conduct together. The single-ended pin takes its idle level at once.

The three idle levels are held in a small configuration register written through a strobe. A nonzero protection level freezes that register, and any write made while protected is dropped without notice. The dead-time length is a cycle count. It is sampled on the last clock edge at which the enable is still high, so the count only needs to be stable while the outputs are running. A count of zero applies the idle levels with no gap.

Top module: `brk_idle_out`

## Requirements
- R1: While `main_en` is 1, `pin_oc1`, `pin_oc1n` and `pin_oc2` equal `pwm_oc1`, `pwm_oc1n` and `pwm_oc2` in the same cycle.
- R2: When `main_en` falls, `pin_oc1` and `pin_oc1n` are both 0 for exactly D clock cycles, where D is the `dead_cycles` value sampled at the last rising edge with `main_en` = 1.
- R3: While `main_en` stays 0 after the dead-time, `pin_oc1` equals stored idle bit 0 and `pin_oc1n` equals stored idle bit 1. With D = 0 this holds from the first cycle with `main_en` = 0.
- R4: In every cycle with `main_en` = 0, `pin_oc2` equals stored idle bit 2, with no dead-time.
- R5: A rising edge with `idle_wr` = 1 and `prot_lvl` = 0 stores `idle_wdata` (bit 0 for the main pin, bit 1 for the complementary pin, bit 2 for the single-ended pin). The pins use the new value from the next cycle.
- R6: A write made while `prot_lvl` is nonzero is ignored, and the stored idle bits keep their earlier values.
- R7: During and just after reset the stored idle bits are 0 and no dead-time is pending, so all pins read 0 while `main_en` is 0.
- R8: If `main_en` returns to 1 during the dead-time, the pins follow the PWM levels in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| main_en | input | 1 | Main output enable |
| pwm_oc1 | input | 1 | Normal level, main pin |
| pwm_oc1n | input | 1 | Normal level, complementary pin |
| pwm_oc2 | input | 1 | Normal level, single-ended pin |
| dead_cycles | input | DT_W | Dead-time length in clock cycles |
| idle_wr | input | 1 | Idle-level write strobe |
| idle_wdata | input | 3 | Idle levels to store: bit0 main, bit1 complementary, bit2 single-ended |
| prot_lvl | input | LOCK_W | Protection level; nonzero blocks writes |
| pin_oc1 | output | 1 | Main pin |
| pin_oc1n | output | 1 | Complementary pin |
| pin_oc2 | output | 1 | Single-ended pin |

## Verification
An idle-level write can land in the same cycle in which the enable falls. The new levels must then appear once the dead-time ends (and on the single-ended pin from the next cycle), never the old ones. The bench drives a write together with the falling enable, both with and without protection. It also restores the enable in the middle of a dead-time, where the reload of the counter and the pass-through meet. A behavioural model holds the dead-time as a plain integer and the idle levels as separate variables, and it judges every cycle.

// File: rtl/brk_idle_pkg.sv
// Package: shared types for the break idle-state output controller.
// Assumes the three idle levels always travel together as one word.
package brk_idle_pkg;

    localparam int IDLE_BITS = 3;

    // Idle levels; bit 0 main pin, bit 1 complementary pin, bit 2 single-ended pin.
    typedef struct packed {
        logic oc2;
        logic oc1n;
        logic oc1;
    } idle_lvl_t;

endpackage

// File: rtl/idle_cfg_regs.sv
// Module: idle_cfg_regs
// Holds the three idle levels. A write is taken only while the protection
// level is zero; otherwise it is dropped silently.
// Assumes: prot_lvl is stable around the clock edge of a write.
module idle_cfg_regs
    import brk_idle_pkg::*;
#(
    parameter int LOCK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  idle_lvl_t         wr_data,
    input  logic [LOCK_W-1:0] prot_lvl,
    output idle_lvl_t         idle_q
);

    logic unlocked;

    // Writes pass only at protection level zero.
    always_comb begin
        unlocked = (prot_lvl == '0);
    end

    // Storage of the idle levels, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_q <= '0;
        end else if (wr_en && unlocked) begin
            idle_q <= wr_data;
        end
    end

endmodule

// File: rtl/dead_timer.sv
// Module: dead_timer
// Counts the dead-time after the main enable drops. While the enable is high,
// it reloads the programmed count on every edge; while it is low, it counts down to zero.
// Assumes: dead_cycles is valid on the last edge with the enable high.
module dead_timer #(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            main_en,
    input  logic [DT_W-1:0] dead_cycles,
    output logic            dead_active
);

    logic [DT_W-1:0] left_q;

    // Reload while running, count down while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (main_en) begin
            left_q <= dead_cycles;
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    // Dead-time is pending only while the enable is low and cycles remain.
    always_comb begin
        dead_active = !main_en && (left_q != '0);
    end

endmodule

// File: rtl/pin_mux.sv
// Module: pin_mux
// Chooses each pin's level: the PWM level while enabled, low during the
// dead-time (pair only), the idle level after it.
// Assumes: dead_active is already gated by the enable.
module pin_mux
    import brk_idle_pkg::*;
(
    input  logic      main_en,
    input  logic      dead_active,
    input  idle_lvl_t pwm_lvl,
    input  idle_lvl_t idle_lvl,
    output idle_lvl_t pin_lvl
);

    // Per-pin selection; the pair obeys the dead-time, the single pin does not.
    always_comb begin
        if (main_en) begin
            pin_lvl = pwm_lvl;
        end else if (dead_active) begin
            pin_lvl.oc1  = 1'b0;
            pin_lvl.oc1n = 1'b0;
            pin_lvl.oc2  = idle_lvl.oc2;
        end else begin
            pin_lvl = idle_lvl;
        end
    end

endmodule

// File: rtl/brk_idle_out.sv
// Module: brk_idle_out (top)
// Drives a complementary pair and a single-ended pin to programmed idle levels
// when the main enable is low, with a dead-time on the pair.
// Assumes: main_en comes from the break logic and is synchronous to clk.
module brk_idle_out
    import brk_idle_pkg::*;
#(
    parameter int DT_W   = 8,
    parameter int LOCK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              main_en,
    input  logic              pwm_oc1,
    input  logic              pwm_oc1n,
    input  logic              pwm_oc2,
    input  logic [DT_W-1:0]   dead_cycles,
    input  logic              idle_wr,
    input  logic [IDLE_BITS-1:0] idle_wdata,
    input  logic [LOCK_W-1:0] prot_lvl,
    output logic              pin_oc1,
    output logic              pin_oc1n,
    output logic              pin_oc2
);

    idle_lvl_t idle_q;
    idle_lvl_t pwm_lvl;
    idle_lvl_t pin_lvl;
    logic      dead_active;

    // Gather the PWM inputs into one word.
    always_comb begin
        pwm_lvl.oc1  = pwm_oc1;
        pwm_lvl.oc1n = pwm_oc1n;
        pwm_lvl.oc2  = pwm_oc2;
    end

    idle_cfg_regs #(.LOCK_W(LOCK_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (idle_wr),
        .wr_data  (idle_lvl_t'(idle_wdata)),
        .prot_lvl (prot_lvl),
        .idle_q   (idle_q)
    );

    dead_timer #(.DT_W(DT_W)) u_dt (
        .clk         (clk),
        .rst_n       (rst_n),
        .main_en     (main_en),
        .dead_cycles (dead_cycles),
        .dead_active (dead_active)
    );

    pin_mux u_mux (
        .main_en     (main_en),
        .dead_active (dead_active),
        .pwm_lvl     (pwm_lvl),
        .idle_lvl    (idle_q),
        .pin_lvl     (pin_lvl)
    );

    // Drive the pins from the selected word.
    always_comb begin
        pin_oc1  = pin_lvl.oc1;
        pin_oc1n = pin_lvl.oc1n;
        pin_oc2  = pin_lvl.oc2;
    end

endmodule

// File: rtl/brk_idle_out_chk.sv
// Module: brk_idle_out_chk
// Assertion checker attached to brk_idle_out by bind.
// Assumes: it sees the top's stored idle word and dead-time flag.
module brk_idle_out_chk #(
    parameter int DT_W   = 8,
    parameter int LOCK_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              main_en,
    input logic              pwm_oc1,
    input logic              pwm_oc1n,
    input logic              pwm_oc2,
    input logic [DT_W-1:0]   dead_cycles,
    input logic              idle_wr,
    input logic [2:0]        idle_wdata,
    input logic [LOCK_W-1:0] prot_lvl,
    input logic              pin_oc1,
    input logic              pin_oc1n,
    input logic              pin_oc2,
    input logic [2:0]        idle_q,
    input logic              dead_active
);

    // R1, R8: the pins pass the PWM levels while enabled.
    a_r1_run_follow: assert property (@(posedge clk) disable iff (!rst_n)
        main_en |-> (pin_oc1 == pwm_oc1 && pin_oc1n == pwm_oc1n && pin_oc2 == pwm_oc2));

    // R2: the first disabled cycle with a nonzero count holds the pair low.
    a_r2_dead_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!main_en && $past(main_en) && $past(dead_cycles) != '0) |-> (!pin_oc1 && !pin_oc1n));

    // R3: after the dead-time, the pair shows its idle levels.
    a_r3_pair_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!main_en && !dead_active) |-> (pin_oc1 == idle_q[0] && pin_oc1n == idle_q[1]));

    // R4: the single-ended pin idles with no delay.
    a_r4_single_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !main_en |-> (pin_oc2 == idle_q[2]));

    // R5: an unprotected write lands on the next edge.
    a_r5_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_wr && prot_lvl == '0) |=> (idle_q == $past(idle_wdata)));

    // R6: protection freezes the stored levels.
    a_r6_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_lvl != '0) |=> $stable(idle_q));

endmodule

bind brk_idle_out brk_idle_out_chk #(.DT_W(DT_W), .LOCK_W(LOCK_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .main_en     (main_en),
    .pwm_oc1     (pwm_oc1),
    .pwm_oc1n    (pwm_oc1n),
    .pwm_oc2     (pwm_oc2),
    .dead_cycles (dead_cycles),
    .idle_wr     (idle_wr),
    .idle_wdata  (idle_wdata),
    .prot_lvl    (prot_lvl),
    .pin_oc1     (pin_oc1),
    .pin_oc1n    (pin_oc1n),
    .pin_oc2     (pin_oc2),
    .idle_q      (idle_q),
    .dead_active (dead_active)
);

// File: tb/brk_idle_out_test.sv
// Bench for brk_idle_out. A behavioural model runs beside the design, and every cycle is compared.
module brk_idle_out_test;

    localparam int DT_W   = 8;
    localparam int LOCK_W = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              main_en = 1'b0;
    logic              pwm_oc1 = 1'b0, pwm_oc1n = 1'b0, pwm_oc2 = 1'b0;
    logic [DT_W-1:0]   dead_cycles = '0;
    logic              idle_wr = 1'b0;
    logic [2:0]        idle_wdata = '0;
    logic [LOCK_W-1:0] prot_lvl = '0;
    logic              pin_oc1, pin_oc1n, pin_oc2;

    int checks = 0;
    int errors = 0;
    int cycle_n = 0;
    bit done = 0;

    // Model state: idle levels as separate bits, the remaining dead cycles as an integer.
    bit m_i1 = 0, m_i1n = 0, m_i2 = 0;
    int m_left = 0;
    bit m_blocked = 0;     // a protected write happened since the last accepted one
    bit m_wrote = 0;       // an accepted write has happened
    bit m_back = 0;        // the enable came back while a dead-time was pending

    always #10 clk = ~clk; // 50 MHz

    brk_idle_out #(.DT_W(DT_W), .LOCK_W(LOCK_W)) uut (
        .clk(clk), .rst_n(rst_n), .main_en(main_en),
        .pwm_oc1(pwm_oc1), .pwm_oc1n(pwm_oc1n), .pwm_oc2(pwm_oc2),
        .dead_cycles(dead_cycles), .idle_wr(idle_wr), .idle_wdata(idle_wdata),
        .prot_lvl(prot_lvl),
        .pin_oc1(pin_oc1), .pin_oc1n(pin_oc1n), .pin_oc2(pin_oc2)
    );

    // Model update at each rising edge from the inputs that are present.
    always @(posedge clk) begin
        cycle_n <= cycle_n + 1;
        if (!rst_n) begin
            m_i1 <= 0; m_i1n <= 0; m_i2 <= 0; m_left <= 0;
            m_blocked <= 0; m_wrote <= 0; m_back <= 0;
        end else begin
            if (idle_wr && prot_lvl == 0) begin
                m_i1 <= idle_wdata[0]; m_i1n <= idle_wdata[1]; m_i2 <= idle_wdata[2];
                m_wrote <= 1; m_blocked <= 0;
            end else if (idle_wr) begin
                m_blocked <= 1;
            end
            if (main_en) m_left <= int'(dead_cycles);
            else if (m_left > 0) m_left <= m_left - 1;
        end
    end

    // Flag the cycle in which the enable returns during a pending dead-time.
    always @(posedge clk) m_back <= (rst_n && !main_en && m_left > 0);

    task automatic cmp(input string tag, input logic got, input logic exp, input string pin);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s pin %s cycle %0d actual %b expected %b", tag, pin, cycle_n, got, exp);
        end
    endtask

    // Compare on every falling edge, away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            string t1, t2;
            logic e1, e1n, e2;
            if (main_en) begin
                e1 = pwm_oc1; e1n = pwm_oc1n; e2 = pwm_oc2;
                t1 = m_back ? "R8" : "R1"; t2 = t1;
            end else begin
                e2 = m_i2;
                t2 = !rst_n ? "R7" : (m_blocked ? "R4 R6" : (m_wrote ? "R4 R5" : "R4 R7"));
                if (m_left > 0) begin
                    e1 = 0; e1n = 0; t1 = "R2";
                end else begin
                    e1 = m_i1; e1n = m_i1n;
                    t1 = !rst_n ? "R7" : (m_blocked ? "R3 R6" : (m_wrote ? "R3 R5" : "R3 R7"));
                end
            end
            cmp(t1, pin_oc1, e1, "oc1");
            cmp(t1, pin_oc1n, e1n, "oc1n");
            cmp(t2, pin_oc2, e2, "oc2");
        end
    end

    // Apply one cycle of stimulus shortly after the falling edge.
    task automatic step(input logic en, input logic [2:0] pwm, input int dt,
                        input logic wr, input logic [2:0] wd, input int lk);
        @(negedge clk);
        #2;
        main_en = en;
        {pwm_oc2, pwm_oc1n, pwm_oc1} = pwm;
        dead_cycles = DT_W'(dt);
        idle_wr = wr; idle_wdata = wd; prot_lvl = LOCK_W'(lk);
    endtask

    task automatic summary;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        if (cycle_n > 150000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired at cycle %0d", cycle_n);
            summary();
            $finish;
        end
    end

    initial begin
        // R7: reset with the enable low
        repeat (3) step(0, 3'b111, 5, 0, 0, 0);
        @(negedge clk); #2; rst_n = 1;
        repeat (2) step(0, 3'b101, 0, 0, 0, 0);
        // R5: unprotected write of all-ones idle levels
        step(0, 0, 0, 1, 3'b111, 0);
        repeat (2) step(0, 0, 0, 0, 0, 0);
        // R1: running with several PWM patterns, dead-time 4
        for (int i = 0; i < 8; i++) step(1, 3'(i), 4, 0, 0, 0);
        // R2, R3: fall with a dead-time of 4
        repeat (7) step(0, 3'b110, 4, 0, 0, 0);
        // R3: fall with a dead-time of 0
        step(1, 3'b001, 0, 0, 0, 0);
        repeat (3) step(0, 3'b001, 0, 0, 0, 0);
        // R6: protected writes at each nonzero level, outputs keep old idle levels
        for (int lk = 1; lk < 4; lk++) step(0, 0, 0, 1, 3'b000, lk);
        repeat (2) step(0, 0, 0, 0, 0, 2);
        step(1, 3'b010, 3, 0, 0, 3);
        repeat (5) step(0, 3'b010, 3, 1, 3'b000, 1);
        // Same cycle: write lands as the enable falls, dead-time 2
        step(1, 3'b011, 2, 0, 0, 0);
        step(0, 3'b011, 2, 1, 3'b010, 0);
        repeat (4) step(0, 3'b011, 2, 0, 0, 0);
        // Same cycle while protected: the falling enable must not pick up the write
        step(1, 3'b100, 2, 0, 0, 1);
        step(0, 3'b100, 2, 1, 3'b101, 1);
        repeat (4) step(0, 3'b100, 2, 0, 0, 0);
        // R8: the enable returns during the dead-time, then a fresh dead-time
        step(1, 3'b101, 6, 0, 0, 0);
        repeat (2) step(0, 3'b101, 6, 0, 0, 0);
        repeat (2) step(1, 3'b110, 3, 0, 0, 0);
        repeat (5) step(0, 3'b110, 3, 0, 0, 0);
        // Mixed traffic
        for (int i = 0; i < 3000; i++) begin
            logic en;
            en = ($urandom_range(0, 9) < 6);
            step(en, 3'($urandom), $urandom_range(0, 5), ($urandom_range(0, 3) == 0),
                 3'($urandom), ($urandom_range(0, 2) == 0) ? $urandom_range(1, 3) : 0);
        end
        step(0, 0, 0, 0, 0, 0);
        @(negedge clk);
        #1;
        done = 1;
        summary();
        $finish;
    end

endmodule